// File: doc/BRIEF.md
# NOR Flash Program Command Sequencer

This block sits on the host side of a parallel NOR flash and converts single-word program requests into the command write cycles that the flash's asynchronous write bus expects. A request carries a target address, a data word, an operation code and a mode bit. The mode bit chooses between the full unlock sequence for every word and the unlock-bypass mode. In bypass mode, after a one-time entry, each word needs only a command cycle and a data cycle.

The sequencer keeps a record of whether the flash is in bypass mode, and it starts in the non-bypass state after reset, as the flash does. It enters bypass automatically before the first bypass-mode program. It leaves bypass before any standard program, and it can also leave bypass on an explicit request. Erase operations are not supported: an erase request is refused with a one-cycle error flag. Every write cycle is timed by two parameters, a setup count and a write-pulse count, followed by one fixed hold cycle. The host side uses a valid/ready handshake, and ready stays low while a sequence runs.

Top module: `nor_prog_sequencer`

## Requirements
- R1: After reset, req_ready is 1, bus_ce_n, bus_we_n and bus_oe_n are 1, and bypass_active and err_flag are 0.
- R2: In every bus write cycle, bus_ce_n is low for exactly SETUP_CYC + PULSE_CYC + 1 consecutive cycles. bus_we_n stays high for the first SETUP_CYC of them, low for the next PULSE_CYC, and high for the final hold cycle. bus_addr and bus_data do not change while bus_ce_n is low, bus_oe_n stays 1, and bus_ce_n returns high between any two write cycles.
- R3: A program request (req_op 2'b00) with req_bypass 0 while bypass is inactive produces exactly four writes: 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then req_data to req_addr.
- R4: A program request with req_bypass 1 while bypass is inactive produces the entry writes 0xAA to 0x555, 0x55 to 0x2AA and 0x20 to 0x555, then 0xA0 to 0x555 and req_data to req_addr, for five writes. bypass_active becomes 1.
- R5: A program request with req_bypass 1 while bypass is active produces exactly two writes: 0xA0 to 0x555, then req_data to req_addr.
- R6: A leave request (req_op 2'b01) while bypass is active produces exactly two writes, 0x90 to 0x000 and then 0x00 to 0x000, and clears bypass_active. A leave request while bypass is inactive produces no write and no error.
- R7: A program request with req_bypass 0 while bypass is active first produces the two leave writes of R6 and then the four writes of R3, for six writes. It ends with bypass_active at 0.
- R8: An erase request (req_op 2'b10 sector, 2'b11 whole device) is refused. err_flag is 1 in the single cycle after acceptance, no bus write occurs, and bypass_active keeps its value.
- R9: A request is accepted only when req_valid and req_ready are both 1. req_ready is 0 from the cycle after a request that issues writes until the last write's hold cycle ends. A request presented while req_ready is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 2 | 00 program, 01 leave bypass, 10 sector erase, 11 device erase |
| req_bypass | input | 1 | Program in bypass mode when 1 |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Word to program |
| bus_addr | output | ADDR_W | Flash address bus |
| bus_data | output | DATA_W | Flash write data bus |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, held high |
| bus_we_n | output | 1 | Write enable, active low |
| err_flag | output | 1 | One-cycle refusal of an erase request |
| bypass_active | output | 1 | The flash is believed to be in bypass mode |

## Verification
The sequencer's riskiest internal state is its bypass flag. A wrong value does not show up as a bad timing edge. It shows up at the bus as the wrong command sequence on the next program: three extra entry writes, a missing leave pair, or a bare 0xA0/data pair sent to a flash that has not been unlocked. Each scenario therefore predicts the exact ordered list of address/data writes from the mode history and compares it with the bus. A wrong flag is caught at the first write of the following request. A faulty step counter or timer is caught within one write cycle, through a write count, order or pulse length that does not match.

// File: rtl/nps_pkg.sv
package nps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAVE_A,
      ST_LEAVE_B,
      ST_UNLOCK_A,
      ST_UNLOCK_B,
      ST_ENTER,
      ST_PROG_CMD,
      ST_PROG_DATA
   } step_e;

   localparam logic [1:0] OP_PROGRAM    = 2'b00;
   localparam logic [1:0] OP_LEAVE      = 2'b01;
   localparam logic [1:0] OP_ERASE_SECT = 2'b10;
   localparam logic [1:0] OP_ERASE_ALL  = 2'b11;

   localparam logic [11:0] ADR_UNLOCK_A = 12'h555;
   localparam logic [11:0] ADR_UNLOCK_B = 12'h2AA;
   localparam logic [11:0] ADR_LEAVE    = 12'h000;

   localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
   localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
   localparam logic [7:0] CMD_ENTER    = 8'h20;
   localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
   localparam logic [7:0] CMD_LEAVE_A  = 8'h90;
   localparam logic [7:0] CMD_LEAVE_B  = 8'h00;

endpackage

// File: rtl/nps_cmd_gen.sv
module nps_cmd_gen
   import nps_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 16
) (
   input  step_e               step,
   input  logic [ADDR_W-1:0]   tgt_addr,
   input  logic [DATA_W-1:0]   tgt_data,
   output logic [ADDR_W-1:0]   cyc_addr,
   output logic [DATA_W-1:0]   cyc_data
);

   localparam int PAD_A = ADDR_W - 12;
   localparam int PAD_D = DATA_W - 8;

   function automatic logic [ADDR_W-1:0] wide_a(input logic [11:0] a);
      return {{PAD_A{1'b0}}, a};
   endfunction

   function automatic logic [DATA_W-1:0] wide_d(input logic [7:0] d);
      return {{PAD_D{1'b0}}, d};
   endfunction

   always_comb begin
      cyc_addr = '0;
      cyc_data = '0;
      case (step)
         ST_LEAVE_A: begin
            cyc_addr = wide_a(ADR_LEAVE);
            cyc_data = wide_d(CMD_LEAVE_A);
         end
         ST_LEAVE_B: begin
            cyc_addr = wide_a(ADR_LEAVE);
            cyc_data = wide_d(CMD_LEAVE_B);
         end
         ST_UNLOCK_A: begin
            cyc_addr = wide_a(ADR_UNLOCK_A);
            cyc_data = wide_d(CMD_UNLOCK_A);
         end
         ST_UNLOCK_B: begin
            cyc_addr = wide_a(ADR_UNLOCK_B);
            cyc_data = wide_d(CMD_UNLOCK_B);
         end
         ST_ENTER: begin
            cyc_addr = wide_a(ADR_UNLOCK_A);
            cyc_data = wide_d(CMD_ENTER);
         end
         ST_PROG_CMD: begin
            cyc_addr = wide_a(ADR_UNLOCK_A);
            cyc_data = wide_d(CMD_PROGRAM);
         end
         ST_PROG_DATA: begin
            cyc_addr = tgt_addr;
            cyc_data = tgt_data;
         end
         default: begin
            cyc_addr = '0;
            cyc_data = '0;
         end
      endcase
   end

endmodule

// File: rtl/nps_wr_timer.sv
module nps_wr_timer #(
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic cyc_on,
   output logic we_on,
   output logic done
);

   localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   typedef enum logic [1:0] {T_IDLE, T_SETUP, T_PULSE, T_HOLD} tstate_e;

   tstate_e state_q, state_d;
   logic    setup_last;
   logic    pulse_last;

   generate
      if (MAX_CYC > 1) begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (state_d != state_q) cnt_q <= '0;
            else                         cnt_q <= cnt_q + 1'b1;
         end
         assign setup_last = (cnt_q == CNT_W'(SETUP_CYC - 1));
         assign pulse_last = (cnt_q == CNT_W'(PULSE_CYC - 1));
      end else begin : g_nocnt
         assign setup_last = 1'b1;
         assign pulse_last = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      case (state_q)
         T_IDLE:  if (start)      state_d = T_SETUP;
         T_SETUP: if (setup_last) state_d = T_PULSE;
         T_PULSE: if (pulse_last) state_d = T_HOLD;
         T_HOLD:                  state_d = T_IDLE;
         default:                 state_d = T_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= T_IDLE;
      else        state_q <= state_d;
   end

   assign cyc_on = (state_q != T_IDLE);
   assign we_on  = (state_q == T_PULSE);
   assign done   = (state_q == T_HOLD);

endmodule

// File: rtl/nps_seq_ctrl.sv
module nps_seq_ctrl
   import nps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   input  logic       req_bypass,
   input  logic       tmr_done,
   output logic       req_ready,
   output logic       accept,
   output step_e      step,
   output logic       kick,
   output logic       err_flag,
   output logic       bypass_on
);

   step_e step_q;
   logic  kick_q, byp_q, std_q, prog_q, err_q;
   step_e first_step;
   logic  first_std;
   logic  first_prog;
   logic  refuse;
   step_e next_step;

   assign req_ready = (step_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      first_step = ST_IDLE;
      first_std  = 1'b0;
      first_prog = 1'b0;
      refuse     = 1'b0;
      case (req_op)
         OP_PROGRAM: begin
            first_prog = 1'b1;
            if (req_bypass) begin
               first_std  = 1'b0;
               first_step = byp_q ? ST_PROG_CMD : ST_UNLOCK_A;
            end else begin
               first_std  = 1'b1;
               first_step = byp_q ? ST_LEAVE_A : ST_UNLOCK_A;
            end
         end
         OP_LEAVE: begin
            first_step = byp_q ? ST_LEAVE_A : ST_IDLE;
         end
         default: refuse = 1'b1;
      endcase
   end

   always_comb begin
      next_step = ST_IDLE;
      case (step_q)
         ST_LEAVE_A:   next_step = ST_LEAVE_B;
         ST_LEAVE_B:   next_step = prog_q ? ST_UNLOCK_A : ST_IDLE;
         ST_UNLOCK_A:  next_step = ST_UNLOCK_B;
         ST_UNLOCK_B:  next_step = std_q ? ST_PROG_CMD : ST_ENTER;
         ST_ENTER:     next_step = ST_PROG_CMD;
         ST_PROG_CMD:  next_step = ST_PROG_DATA;
         ST_PROG_DATA: next_step = ST_IDLE;
         default:      next_step = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         kick_q <= 1'b0;
         byp_q  <= 1'b0;
         std_q  <= 1'b0;
         prog_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         kick_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            err_q  <= refuse;
            step_q <= first_step;
            kick_q <= (first_step != ST_IDLE);
            std_q  <= first_std;
            prog_q <= first_prog;
         end else if (tmr_done && step_q != ST_IDLE) begin
            step_q <= next_step;
            kick_q <= (next_step != ST_IDLE);
            if (step_q == ST_ENTER)   byp_q <= 1'b1;
            if (step_q == ST_LEAVE_B) byp_q <= 1'b0;
         end
      end
   end

   assign step      = step_q;
   assign kick      = kick_q;
   assign err_flag  = err_q;
   assign bypass_on = byp_q;

endmodule

// File: rtl/nor_prog_sequencer.sv
module nor_prog_sequencer
   import nps_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int DATA_W    = 16,
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 3,
   parameter bit PARK_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic              req_bypass,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_ce_n,
   output logic              bus_oe_n,
   output logic              bus_we_n,
   output logic              err_flag,
   output logic              bypass_active
);

   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must hold the 12-bit unlock addresses");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold an 8-bit command");
   end
   if (SETUP_CYC < 1 || PULSE_CYC < 1) begin : g_bad_time
      $error("SETUP_CYC and PULSE_CYC must be at least 1");
   end

   logic              accept;
   logic              kick;
   logic              tmr_done;
   logic              cyc_on;
   logic              we_on;
   step_e             step;
   logic [ADDR_W-1:0] tgt_addr_q;
   logic [DATA_W-1:0] tgt_data_q;
   logic [ADDR_W-1:0] cyc_addr;
   logic [DATA_W-1:0] cyc_data;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   nps_seq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_bypass (req_bypass),
      .tmr_done   (tmr_done),
      .req_ready  (req_ready),
      .accept     (accept),
      .step       (step),
      .kick       (kick),
      .err_flag   (err_flag),
      .bypass_on  (bypass_active)
   );

   nps_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .step     (step),
      .tgt_addr (tgt_addr_q),
      .tgt_data (tgt_data_q),
      .cyc_addr (cyc_addr),
      .cyc_data (cyc_data)
   );

   nps_wr_timer #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (kick),
      .cyc_on (cyc_on),
      .we_on  (we_on),
      .done   (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_addr_q <= '0;
         tgt_data_q <= '0;
      end else if (accept) begin
         tgt_addr_q <= req_addr;
         tgt_data_q <= req_data;
      end
   end

   generate
      if (PARK_IDLE) begin : g_park
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
               data_q <= '0;
            end else if (kick) begin
               addr_q <= cyc_addr;
               data_q <= cyc_data;
            end else if (!cyc_on) begin
               addr_q <= '0;
               data_q <= '0;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
               data_q <= '0;
            end else if (kick) begin
               addr_q <= cyc_addr;
               data_q <= cyc_data;
            end
         end
      end
   endgenerate

   assign bus_addr = addr_q;
   assign bus_data = data_q;
   assign bus_ce_n = ~cyc_on;
   assign bus_we_n = ~we_on;
   assign bus_oe_n = 1'b1;

endmodule

// File: rtl/nor_prog_sequencer_chk.sv
module nor_prog_sequencer_chk #(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_ce_n,
   input logic              bus_we_n,
   input logic              err_flag,
   input logic              bypass_active
);

   AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> !bus_ce_n); // R2

   AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ce_n && $past(!bus_ce_n)) |-> ($stable(bus_addr) && $stable(bus_data))); // R2

   AST_SETUP_BEFORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_we_n) |-> $past(!bus_ce_n)); // R2

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ce_n |-> !req_ready); // R9

   AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> bus_ce_n); // R8

   AST_BYPASS_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bypass_active) |-> $past(!bus_ce_n)); // R4

   AST_BYPASS_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bypass_active) |-> $past(!bus_ce_n)); // R6

endmodule

bind nor_prog_sequencer nor_prog_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .bus_addr      (bus_addr),
   .bus_data      (bus_data),
   .bus_ce_n      (bus_ce_n),
   .bus_we_n      (bus_we_n),
   .err_flag      (err_flag),
   .bypass_active (bypass_active)
);

// File: tb/nor_prog_sequencer_tb.sv
module nor_prog_sequencer_tb;

   localparam int ADDR_W = 22;
   localparam int DATA_W = 16;
   localparam int SETUP  = 2;
   localparam int PULSE  = 3;
   localparam int W      = ADDR_W + DATA_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [1:0]        req_op = 2'b00;
   logic              req_bypass = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_data = '0;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_data;
   logic              bus_ce_n, bus_oe_n, bus_we_n, err_flag, bypass_active;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   logic [W-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   nor_prog_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                        .SETUP_CYC(SETUP), .PULSE_CYC(PULSE)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_bypass(req_bypass), .req_addr(req_addr), .req_data(req_data),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
      .bus_we_n(bus_we_n), .err_flag(err_flag), .bypass_active(bypass_active));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [11:0] a, input logic [DATA_W-1:0] d);
      exp_q.push_back({ADDR_W'(a), d});
   endtask

   task automatic push_std(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      push(12'h555, 16'h00AA); push(12'h2AA, 16'h0055); push(12'h555, 16'h00A0);
      exp_q.push_back({a, d});
   endtask

   task automatic push_byp(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      push(12'h555, 16'h00A0);
      exp_q.push_back({a, d});
   endtask

   task automatic push_leave();
      push(12'h000, 16'h0090); push(12'h000, 16'h0000);
   endtask

   // Issues a request; returns at the first negedge after acceptance.
   task automatic issue(input logic [1:0] op, input logic byp,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_bypass = byp; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_seq(input string tag);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   // Monitor / scoreboard: tracks each write cycle at negedges.
   logic prev_ce_low = 1'b0;
   logic rose_seen = 1'b0;
   int   setup_n = 0, pulse_n = 0;
   logic [ADDR_W-1:0] prev_addr;
   logic [DATA_W-1:0] prev_data;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!bus_oe_n) chk(1'b0, "R2 oe_n high", bus_oe_n, 1);
         if (!bus_ce_n) begin
            if (!prev_ce_low) begin
               setup_n = 0; pulse_n = 0; rose_seen = 1'b0;
            end else if (bus_addr != prev_addr || bus_data != prev_data) begin
               chk(1'b0, "R2 addr/data stable", {bus_addr, bus_data}, {prev_addr, prev_data});
            end
            if (rose_seen) begin
               chk(1'b0, "R2 hold is one cycle", 2, 1);
            end else if (!bus_we_n) begin
               pulse_n++;
            end else if (pulse_n == 0) begin
               setup_n++;
            end else begin
               rose_seen = 1'b1;
               chk(setup_n == SETUP, "R2 setup count", setup_n, SETUP);
               chk(pulse_n == PULSE, "R2 pulse count", pulse_n, PULSE);
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R3 unexpected write", {bus_addr, bus_data}, 0);
               end else begin
                  logic [W-1:0] e;
                  e = exp_q.pop_front();
                  chk({bus_addr, bus_data} == e, "R3 write order addr/data",
                      {bus_addr, bus_data}, e);
               end
            end
         end else if (prev_ce_low && !rose_seen) begin
            chk(1'b0, "R2 write cycle cut short", 0, 1);
         end
         prev_ce_low = !bus_ce_n;
         prev_addr   = bus_addr;
         prev_data   = bus_data;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         chk(1'b0, "watchdog expired", cycles, 100000);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      chk({bus_ce_n, bus_we_n, bus_oe_n} == 3'b111, "R1 bus idle", {bus_ce_n, bus_we_n, bus_oe_n}, 3'b111);
      chk({bypass_active, err_flag} == 2'b00, "R1 flags", {bypass_active, err_flag}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 standard program
      push_std(22'h12345, 16'hBEEF);
      issue(2'b00, 1'b0, 22'h12345, 16'hBEEF);
      chk(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
      finish_seq("R3 four writes");
      chk(bypass_active == 1'b0, "R3 bypass stays off", bypass_active, 0);

      // R4 bypass program with entry
      push(12'h555, 16'h00AA); push(12'h2AA, 16'h0055); push(12'h555, 16'h0020);
      push_byp(22'h3FFFFF, 16'h0001);
      issue(2'b00, 1'b1, 22'h3FFFFF, 16'h0001);
      finish_seq("R4 five writes");
      chk(bypass_active == 1'b1, "R4 bypass set", bypass_active, 1);

      // R5 two short programs
      push_byp(22'h000010, 16'hA5A5);
      issue(2'b00, 1'b1, 22'h000010, 16'hA5A5);
      finish_seq("R5 two writes a");
      push_byp(22'h2AAAAA, 16'h5A5A);
      issue(2'b00, 1'b1, 22'h2AAAAA, 16'h5A5A);
      finish_seq("R5 two writes b");
      chk(bypass_active == 1'b1, "R5 bypass kept", bypass_active, 1);

      // R8 sector erase refused while bypass on
      issue(2'b10, 1'b0, 22'h1, 16'h1);
      chk(err_flag == 1'b1, "R8 err pulse", err_flag, 1);
      chk(req_ready == 1'b1, "R8 ready stays", req_ready, 1);
      @(negedge clk);
      chk(err_flag == 1'b0, "R8 err one cycle", err_flag, 0);
      chk(bus_ce_n == 1'b1, "R8 no write", bus_ce_n, 1);
      chk(bypass_active == 1'b1, "R8 bypass unchanged", bypass_active, 1);

      // R6 leave bypass
      push_leave();
      issue(2'b01, 1'b0, 22'h0, 16'h0);
      finish_seq("R6 leave writes");
      chk(bypass_active == 1'b0, "R6 bypass cleared", bypass_active, 0);

      // R6 leave while inactive: nothing happens
      issue(2'b01, 1'b0, 22'h0, 16'h0);
      chk(req_ready == 1'b1 && err_flag == 1'b0, "R6 idle leave no-op", {req_ready, err_flag}, 2'b10);
      repeat (4) begin
         @(negedge clk);
         chk(bus_ce_n == 1'b1, "R6 idle leave no write", bus_ce_n, 1);
      end

      // enter bypass again, then R7 standard program while bypass on
      push(12'h555, 16'h00AA); push(12'h2AA, 16'h0055); push(12'h555, 16'h0020);
      push_byp(22'h000777, 16'h1234);
      issue(2'b00, 1'b1, 22'h000777, 16'h1234);
      finish_seq("R4 re-entry");
      push_leave();
      push_std(22'h0ABCDE, 16'hCAFE);
      issue(2'b00, 1'b0, 22'h0ABCDE, 16'hCAFE);
      // R9 a request during the sequence is ignored
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_op = 2'b11;
      repeat (4) begin
         @(negedge clk);
         chk(req_ready == 1'b0 && err_flag == 1'b0, "R9 held off while busy",
             {req_ready, err_flag}, 0);
      end
      req_valid = 1'b0; req_op = 2'b00;
      finish_seq("R7 six writes");
      chk(bypass_active == 1'b0, "R7 bypass cleared", bypass_active, 0);

      // R8 device erase refused
      issue(2'b11, 1'b0, 22'h0, 16'h0);
      chk(err_flag == 1'b1, "R8 device erase err", err_flag, 1);
      @(negedge clk);
      chk(bus_ce_n == 1'b1 && bypass_active == 1'b0, "R8 device erase quiet",
          {bus_ce_n, bypass_active}, 2'b10);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule